// File: doc/BRIEF.md
# Register-List Multiple Transfer Sequencer

This block turns one 8-bit register mask into a series of word accesses on a simple request/acknowledge bus. It supports four transfer kinds: a stack push, a stack pop, a block load from a base address and a block store to a base address. For each set mask bit it presents an address, a direction, a sequential-access hint and the register index. On loads it returns the read word to the register file. On stores it forwards the register value that the register file supplies for the index on offer. When the transfer ends it gives back the updated stack pointer or base value.

A push and a pop can also carry one extra register beyond the eight mask bits. A push stores the link register before the others. A pop loads the program counter after the others and asks for a pipeline flush. The caller pulses `start` with the mode, mask, extra flag and the current stack pointer or base value. It then serves bus requests until `done` pulses together with the write-back of the new base.

Top module: `reglist_xfer_seq`

## Requirements
- R1: Mode 0 (push) walks downward. When `extraEn` is set it first stores index 8 (link register) at base-4. It then stores each set mask bit from index 7 down to 0, each at an address 4 below the previous access. The written-back base is base-4n, where n is the number of accesses.
- R2: Mode 1 (pop) loads the set mask bits from index 0 up to 7, starting at base and stepping up by 4. When `extraEn` is set it loads index 8 (program counter) last. It raises `flushReq` in the cycle that program-counter word is written. The written-back base is base+4n.
- R3: Mode 2 (block load) and mode 3 (block store) walk the set mask bits from index 0 up to 7, starting at base and stepping up by 4. They write back base+4n. `extraEn` has no effect in these modes.
- R4: `busSeq` is 0 on the first access of a transfer and 1 on every later access. It is 0 again before the next transfer starts.
- R5: After the last acknowledged read of a load mode (1 or 2), one internal cycle passes with no request and no `done`, and `done` follows in the next cycle. In a store mode (0 or 3), `done` comes in the cycle right after the last acknowledge.
- R6: An empty mask with no extra register makes no bus request. `done` comes in the first cycle after `start` is taken, and the written-back base equals `baseIn`.
- R7: While `busReq` is high and `busAck` is low, the request, address, direction and index stay unchanged.
- R8: On a load, `regWrEn` is high in the acknowledge cycle, with `regWrIdx` equal to the access index and `regWrData` equal to `busRdata`. On a store, `busWdata` equals `regRdData` for the index shown on `regRdIdx`, and `regWrEn` stays low.
- R9: `done` and `baseWrEn` form a single-cycle pulse. A `start` that arrives while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer when idle |
| mode | input | 2 | 0 push, 1 pop, 2 block load, 3 block store |
| regMask | input | 8 | Register selection mask |
| extraEn | input | 1 | Include link register (push) or program counter (pop) |
| baseIn | input | 32 | Current stack pointer or base address |
| busReq | output | 1 | Bus access request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busSeq | output | 1 | Sequential-access hint |
| busAddr | output | 32 | Access address |
| busWdata | output | 32 | Store data |
| busAck | input | 1 | Access completes this cycle |
| busRdata | input | 32 | Load data, valid with busAck |
| regRdIdx | output | 4 | Register index whose value is being stored (8 = extra) |
| regRdData | input | 32 | Register file value for regRdIdx |
| regWrEn | output | 1 | Register write strobe on load |
| regWrIdx | output | 4 | Register index being loaded (8 = extra) |
| regWrData | output | 32 | Value written to the register |
| flushReq | output | 1 | Program counter loaded; pipeline flush |
| baseWrEn | output | 1 | Write-back strobe for the new base |
| baseWrData | output | 32 | Final stack pointer or base value |
| done | output | 1 | Transfer complete pulse |

## Verification
The assertions assume that `busAck` is only raised while `busRdata` is valid and `busReq` is high. They also assume that `regRdData` follows `regRdIdx` combinationally within the same cycle. The bench acts as the bus. It raises `busAck` only on a cycle where it sees a request, after a latency of zero to two cycles chosen by mask and mode, and it drops the acknowledge at the next falling edge. It sweeps every mask with and without the extra bit in all four modes. On some runs it pulses `start` with changed inputs in the middle of a transfer, so that R9 is exercised without breaking the assumptions above.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [1:0] {
    MODE_PUSH      = 2'd0,
    MODE_POP       = 2'd1,
    MODE_BLK_LOAD  = 2'd2,
    MODE_BLK_STORE = 2'd3
  } xferMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_SETTLE,
    ST_FINISH
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch base, clear sequential hint
    logic advance;  // one access acknowledged
    logic finish;   // transfer complete
  } ctlStrobe_t;
endpackage

// File: rtl/mxs_ctrl.sv
module mxs_ctrl
  import mxs_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int IW = $clog2(NREGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [NREGS-1:0] regMask,
  input  logic             extraEn,
  input  logic             busAck,
  output ctlStrobe_t       strobe,
  output logic             descend,
  output logic             busReq,
  output logic             busWrite,
  output logic [IW-1:0]    curIdx,
  output logic             regWrEn,
  output logic             flushReq,
  output logic             done
);
  seqState_e state, stateNxt;
  xferMode_e modeQ;
  logic [NREGS:0] pend, pendNxt, startSet, pickHot;
  logic [IW-1:0]  pickIdx;
  logic isLoad, accept, lastOne, extraMode;

  assign extraMode = (xferMode_e'(mode) == MODE_PUSH) || (xferMode_e'(mode) == MODE_POP);
  assign startSet  = {extraEn && extraMode, regMask};
  assign descend   = (modeQ == MODE_PUSH);
  assign isLoad    = (modeQ == MODE_POP) || (modeQ == MODE_BLK_LOAD);

  // index selection: highest pending when walking down, lowest otherwise
  always_comb begin
    pickIdx = '0;
    if (descend) begin
      for (int i = 0; i <= NREGS; i++)
        if (pend[i]) pickIdx = IW'(i);
    end else begin
      for (int i = NREGS; i >= 0; i--)
        if (pend[i]) pickIdx = IW'(i);
    end
  end

  assign pickHot = {{NREGS{1'b0}}, 1'b1} << pickIdx;
  assign pendNxt = pend & ~pickHot;
  assign lastOne = (pendNxt == '0);
  assign accept  = (state == ST_XFER) && busAck;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (start) stateNxt = (startSet == '0) ? ST_FINISH : ST_XFER;
      ST_XFER:   if (busAck && lastOne) stateNxt = isLoad ? ST_SETTLE : ST_FINISH;
      ST_SETTLE: stateNxt = ST_FINISH;
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= '0;
      modeQ <= MODE_PUSH;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && start) begin
        pend  <= startSet;
        modeQ <= xferMode_e'(mode);
      end else if (accept) begin
        pend <= pendNxt;
      end
    end
  end

  assign strobe.capture = (state == ST_IDLE) && start;
  assign strobe.advance = accept;
  assign strobe.finish  = (state == ST_FINISH);

  assign busReq   = (state == ST_XFER);
  assign busWrite = !isLoad;
  assign curIdx   = pickIdx;
  assign regWrEn  = accept && isLoad;
  assign flushReq = regWrEn && (pickIdx == IW'(NREGS)) && (modeQ == MODE_POP);
  assign done     = (state == ST_FINISH);

  // R7: an unacknowledged request is held unchanged
  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(curIdx) && $stable(busWrite));

  // R5: a load leaves one quiet cycle after its final read
  assert_load_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept && lastOne && isLoad |=> !busReq && !done);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: nothing to move means completion on the next cycle
  assert_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && start && (startSet == '0) |=> done && !busReq);
endmodule

// File: rtl/mxs_dpath.sv
module mxs_dpath
  import mxs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          descend,
  input  logic [AW-1:0] baseIn,
  output logic [AW-1:0] busAddr,
  output logic          busSeq,
  output logic [AW-1:0] baseOut
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic [AW-1:0] ptr;
  logic          seqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr  <= '0;
      seqQ <= 1'b0;
    end else if (strobe.capture) begin
      ptr  <= baseIn;
      seqQ <= 1'b0;
    end else if (strobe.advance) begin
      ptr  <= descend ? ptr - STEP_W : ptr + STEP_W;
      seqQ <= 1'b1;
    end else if (strobe.finish) begin
      seqQ <= 1'b0;
    end
  end

  // pre-decrement on the downward walk, post-increment otherwise
  assign busAddr = descend ? ptr - STEP_W : ptr;
  assign busSeq  = seqQ;
  assign baseOut = ptr;

  // R3: each acknowledged access moves the pointer by one word
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (ptr == $past(ptr) + STEP_W) || (ptr == $past(ptr) - STEP_W));

  // R4: first access non-sequential, later ones sequential
  assert_seq_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !busSeq);
  assert_seq_after_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> busSeq);
endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq
  import mxs_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int STEP  = 4,
  localparam int IW   = $clog2(NREGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [NREGS-1:0] regMask,
  input  logic             extraEn,
  input  logic [AW-1:0]    baseIn,
  output logic             busReq,
  output logic             busWrite,
  output logic             busSeq,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWdata,
  input  logic             busAck,
  input  logic [DW-1:0]    busRdata,
  output logic [IW-1:0]    regRdIdx,
  input  logic [DW-1:0]    regRdData,
  output logic             regWrEn,
  output logic [IW-1:0]    regWrIdx,
  output logic [DW-1:0]    regWrData,
  output logic             flushReq,
  output logic             baseWrEn,
  output logic [AW-1:0]    baseWrData,
  output logic             done
);
  ctlStrobe_t    strobe;
  logic          descend, doneInt;
  logic [IW-1:0] curIdx;

  mxs_ctrl #(.NREGS(NREGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .regMask(regMask), .extraEn(extraEn), .busAck(busAck),
    .strobe(strobe), .descend(descend), .busReq(busReq),
    .busWrite(busWrite), .curIdx(curIdx), .regWrEn(regWrEn),
    .flushReq(flushReq), .done(doneInt)
  );

  mxs_dpath #(.AW(AW), .STEP(STEP)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .descend(descend),
    .baseIn(baseIn), .busAddr(busAddr), .busSeq(busSeq),
    .baseOut(baseWrData)
  );

  assign regRdIdx  = curIdx;
  assign regWrIdx  = curIdx;
  assign busWdata  = regRdData;
  assign regWrData = busRdata;
  assign done      = doneInt;
  assign baseWrEn  = doneInt;
endmodule

// File: tb/reglist_xfer_seq_tb.sv
module reglist_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] regMask = 8'd0;
  logic extraEn = 1'b0;
  logic [31:0] baseIn = 32'd0;
  logic busReq, busWrite, busSeq;
  logic [31:0] busAddr, busWdata;
  logic busAck = 1'b0;
  logic [31:0] busRdata = 32'd0;
  logic [3:0] regRdIdx, regWrIdx;
  logic [31:0] regRdData, regWrData, baseWrData;
  logic regWrEn, flushReq, baseWrEn, done;
  int checkCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  assign regRdData = 32'hC0DE_0000 | {28'd0, regRdIdx};

  reglist_xfer_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .regMask(regMask),
    .extraEn(extraEn), .baseIn(baseIn), .busReq(busReq), .busWrite(busWrite),
    .busSeq(busSeq), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .regRdIdx(regRdIdx), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .flushReq(flushReq), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runXfer(input int md, input logic [7:0] m, input logic ex,
                         input logic [31:0] b, input int lat, input bit poke);
    int eIdx[9];
    logic [31:0] eAddr[9];
    int n = 0;
    int k = 0;
    int lastAck = -1;
    int waited = 0;
    bit fin = 0;
    logic [31:0] p = b;
    bit isLd = (md == 1) || (md == 2);
    bit useEx = ex && (md < 2);
    if (md == 0) begin
      if (useEx) begin p -= 4; eIdx[n] = 8; eAddr[n] = p; n++; end   // R1 link first
      for (int i = 7; i >= 0; i--)
        if (m[i]) begin p -= 4; eIdx[n] = i; eAddr[n] = p; n++; end
    end else begin
      for (int i = 0; i < 8; i++)
        if (m[i]) begin eIdx[n] = i; eAddr[n] = p; p += 4; n++; end
      if (useEx) begin eIdx[n] = 8; eAddr[n] = p; p += 4; n++; end   // R2 program counter last
    end
    check(!busReq && !busSeq, "R4 idle before start", {30'd0, busReq, busSeq}, 32'd0);
    start = 1'b1; mode = 2'(md); regMask = m; extraEn = ex; baseIn = b;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 200 && !fin; c++) begin
      if (poke && c == 0) begin
        start = 1'b1; mode = 2'(md ^ 1); regMask = ~m; extraEn = ~ex; baseIn = ~b;
      end
      if (c == 1) start = 1'b0;
      if (busReq) begin
        check(k < n, "R6 unexpected access", k, n);
        if (k < n) begin
          check(busAddr == eAddr[k], "R1 R2 R3 address", busAddr, eAddr[k]);
          check(regRdIdx == 4'(eIdx[k]), "R1 R2 R3 order", regRdIdx, eIdx[k]);
          check(busWrite == !isLd, "R3 direction", busWrite, !isLd);
          check(busSeq == (k > 0), "R4 sequential hint", busSeq, k > 0);
          check(!done, "R9 done during access", done, 0);
          if (!isLd)
            check(busWdata == (32'hC0DE_0000 | eIdx[k]), "R8 store data", busWdata, 32'hC0DE_0000 | eIdx[k]);
          if (waited == lat) begin
            busRdata = 32'h5A00_0000 ^ eAddr[k];
            busAck = 1'b1;
            #1;
            if (isLd) begin
              check(regWrEn && regWrIdx == 4'(eIdx[k]) && regWrData == busRdata,
                    "R8 load write", {regWrEn, regWrIdx, regWrData[26:0]}, {1'b1, 4'(eIdx[k]), busRdata[26:0]});
              check(flushReq == (md == 1 && eIdx[k] == 8), "R2 flush", flushReq, md == 1 && eIdx[k] == 8);
            end else begin
              check(!regWrEn && !flushReq, "R8 no write on store", {regWrEn, flushReq}, 0);
            end
            lastAck = c; k++; waited = 0;
          end else begin
            waited++;   // R7 held request re-checked next cycle
          end
        end
      end else if (done) begin
        check(k == n, "R6 access count", k, n);
        check(c == ((n == 0) ? 0 : lastAck + (isLd ? 2 : 1)), "R5 done timing", c,
              (n == 0) ? 0 : lastAck + (isLd ? 2 : 1));
        check(baseWrEn && baseWrData == p, "R1 R2 R3 R6 base write-back", baseWrData, p);
        fin = 1;
      end else begin
        check(isLd && n > 0 && k == n && c == lastAck + 1, "R5 idle gap", c, lastAck + 1);
      end
      @(negedge clk);
      busAck = 1'b0;
    end
    check(fin, "R9 completion", fin, 1);
    check(!done && !baseWrEn, "R9 single pulse", {done, baseWrEn}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL R9 watchdog act=0 exp=1");
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busReq && !done && !busSeq && !regWrEn && !baseWrEn, "R9 reset state",
          {busReq, done, busSeq, regWrEn, baseWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int md = 0; md < 4; md++)
      for (int ex = 0; ex < 2; ex++)
        for (int m = 0; m < 256; m++)
          runXfer(md, 8'(m), 1'(ex), 32'h0000_1000 + 32'(m * 16), (m + md) % 3, (m % 17) == 5);
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule